// File: doc/BRIEF.md
# Dual-Channel Sample Framer

This block takes floating-point samples from two digitizer channels and turns them into one frame word per bunch clock for a serializer further downstream. Each sample is a short exponent and mantissa plus a time-slice tag that names which of the digitizer's pipeline stages produced it. A small capture stage on each channel absorbs the skew between the two digitizer clocks: the sample can be taken on the rising or the falling clock edge, and one extra clock of delay can be added. The aligned tags of the two channels are compared with each other, and each channel's tag is followed through its fixed rotation.

When the bunch-crossing-zero marker arrives, the next frame is an orbit word rather than data. In the same cycle a one-cycle reset pulse goes to the digitizers so that their tags restart at zero, and sample frames resume on the following cycle. A test mode replaces sample frames with the contents of a bank of pattern registers, sent in rotation, so the data path can be checked from end to end.

Frame layout with default parameters (21 bits): bits [20:19] hold the kind code (00 sample, 01 orbit, 10 pattern). In a sample frame, bit 18 is the valid bit, [17:16] is tag 1, [15:9] is sample 1, [8:7] is tag 0 and [6:0] is sample 0. An orbit frame carries the orbit signature in [18:2] and the two sticky sequence-error bits in [1:0]. A pattern frame carries the register index in [12:8] and the register contents in [7:0], with all other payload bits zero.

Top module: `dual_chan_framer`

## Requirements
- R1: While reset is held and right after it, frame_o, seq_err_o, tag_mismatch_o and dig_rst_o are all zero.
- R2: With both channels set to rising-edge capture and no extra delay, the sample frame seen after rising edge n carries the samples and tags that were presented before edge n-1, laid out as the sample frame format above with kind 00.
- R3: The extra-delay bit of a channel (align_cfg_i bit 2c for channel c) adds exactly one clock to that channel only. A channel that is one cycle early therefore lines up with the other channel.
- R4: The falling-edge bit of a channel (align_cfg_i bit 2c+1) samples that channel on the falling edge and moves it on at the next rising edge. An input that changes between a falling edge and the next rising edge reaches the frame one clock later than it does with rising-edge capture.
- R5: In the cycle that a sample frame carries two different tags, tag_mismatch_o is 1 and the valid bit is 0. Otherwise tag_mismatch_o is 0.
- R6: seq_err_o[c] sets when channel c's aligned tag is not its previous aligned tag plus one (modulo 4, so 3 is followed by 0). The bit stays set until err_clr_i is sampled high, which clears both bits and takes priority over a new error.
- R7: A bc0_i sampled high at an edge makes the frame after that edge an orbit frame (kind 01, signature 17'h15A3C, sticky error bits in [1:0]) and drives dig_rst_o high for that one cycle. The next frame goes back to samples unless another marker arrives.
- R8: After reset and after each marker, sequence checking on a channel is suspended until that channel's aligned tag equals 0. The restart of the tags therefore raises no error.
- R9: While test_mode_i is high and no marker is present, frames have kind 10 and send pattern registers 0 through 19 in order, one per cycle. The index starts at 0 and wraps after 19. The orbit frame takes priority over pattern frames.
- R10: pat_we_i writes pat_wdata_i to the pattern register selected by pat_addr_i. A write to an address of 20 or more changes no register.
- R11: The valid bit of a sample frame is 1 only when both channels have re-armed their sequence checks and the two tags are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch0_smp_i | input | 7 | Channel 0 sample (exponent above mantissa) |
| ch0_tag_i | input | 2 | Channel 0 time-slice tag |
| ch1_smp_i | input | 7 | Channel 1 sample |
| ch1_tag_i | input | 2 | Channel 1 time-slice tag |
| align_cfg_i | input | 4 | Per channel: bit 2c adds a delay, bit 2c+1 selects falling-edge capture |
| bc0_i | input | 1 | Bunch-crossing-zero marker |
| test_mode_i | input | 1 | Send pattern registers instead of samples |
| err_clr_i | input | 1 | Clear the sticky sequence errors |
| pat_we_i | input | 1 | Pattern register write strobe |
| pat_addr_i | input | 5 | Pattern register address |
| pat_wdata_i | input | 8 | Pattern register write data |
| frame_o | output | 21 | Frame word to the serializer |
| seq_err_o | output | 2 | Sticky per-channel tag sequence error |
| tag_mismatch_o | output | 1 | Aligned tags of the two channels differ |
| dig_rst_o | output | 1 | One-cycle digitizer reset after the marker |

## Verification
The properties assume that bc0_i, test_mode_i and err_clr_i are stable around each rising edge and that the marker is a single-cycle pulse. The stimulus drives every input a fixed delay after the rising edge, and for the falling-edge cases it drives just after the falling edge, so each capture edge sees one settled value. Tags are generated as a running count that restarts at zero in the same cycle as the marker. A single corrupted tag is injected on purpose to trigger the mismatch and the sequence error. The alignment settings are changed only while no error bit is being observed, and a clear pulse follows each change.

// File: rtl/dfr_pkg.sv
`timescale 1ns/1ps
package dfr_pkg;
   localparam int KIND_W = 2;
   typedef enum logic [KIND_W-1:0] {
      FK_SAMPLE  = 2'b00,
      FK_ORBIT   = 2'b01,
      FK_PATTERN = 2'b10
   } frame_kind_e;
endpackage

// File: rtl/dfr_chan_align.sv
`timescale 1ns/1ps
// One channel's capture stage: optional falling-edge capture, then an optional extra clock.
module dfr_chan_align #(
   parameter int W        = 9,
   parameter bit HAS_FALL = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_word,
   input  logic         fall_cap,
   input  logic         add_dly,
   output logic [W-1:0] out_word
);
   logic [W-1:0] fall_q;
   logic [W-1:0] cap_q;
   logic [W-1:0] dly_q;
   logic [W-1:0] cap_src;

   generate
      if (HAS_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q <= '0;
            else        fall_q <= in_word;
         end
         assign cap_src = fall_cap ? fall_q : in_word;
      end else begin : g_rise_only
         assign fall_q  = '0;
         assign cap_src = in_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
         dly_q <= '0;
      end else begin
         cap_q <= cap_src;
         dly_q <= cap_q;
      end
   end

   assign out_word = add_dly ? dly_q : cap_q;
endmodule

// File: rtl/dfr_tag_monitor.sv
`timescale 1ns/1ps
// Follows each channel's tag rotation and compares the channels with each other.
module dfr_tag_monitor #(
   parameter int TAG_W = 2,
   parameter int NCH   = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH*TAG_W-1:0] tags,
   input  logic                 resync,
   input  logic                 clr,
   output logic [NCH-1:0]       seq_err,
   output logic [NCH-1:0]       armed,
   output logic                 mismatch
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic [TAG_W-1:0] cur;
         logic [TAG_W-1:0] prev_q;
         logic             arm_q;
         logic             err_q;
         assign cur = tags[c*TAG_W +: TAG_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= '0;
               arm_q  <= 1'b0;
               err_q  <= 1'b0;
            end else begin
               prev_q <= cur;
               if (resync)      arm_q <= 1'b0;
               else if (!arm_q) arm_q <= (cur == '0);
               if (clr)
                  err_q <= 1'b0;
               else if (arm_q && !resync && (cur != TAG_W'(prev_q + 1'b1)))
                  err_q <= 1'b1;
            end
         end
         assign seq_err[c] = err_q;
         assign armed[c]   = arm_q;
      end
   endgenerate

   always_comb begin
      mismatch = 1'b0;
      for (int c = 1; c < NCH; c++)
         if (tags[c*TAG_W +: TAG_W] != tags[TAG_W-1:0]) mismatch = 1'b1;
   end
endmodule

// File: rtl/dfr_frame_mux.sv
`timescale 1ns/1ps
// Holds the pattern bank and picks the frame to send: orbit, then pattern, then samples.
module dfr_frame_mux
   import dfr_pkg::*;
#(
   parameter int          SLOTS_W   = 18,
   parameter int          NCH       = 2,
   parameter int          NPAT      = 20,
   parameter int          PAT_W     = 8,
   parameter int          PIDX_W    = 5,
   parameter int          FRAME_W   = 21,
   parameter logic [31:0] ORBIT_SIG = 32'h0001_5A3C,
   localparam int         SIG_W     = FRAME_W - KIND_W - NCH
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SLOTS_W-1:0] slots,
   input  logic               valid_in,
   input  logic               bc0,
   input  logic               test_mode,
   input  logic [NCH-1:0]     seq_err,
   input  logic               pat_we,
   input  logic [PIDX_W-1:0]  pat_addr,
   input  logic [PAT_W-1:0]   pat_wdata,
   output logic [FRAME_W-1:0] frame
);
   logic [PAT_W-1:0]   pat_q [NPAT];
   logic [PIDX_W-1:0]  idx_q;
   logic [FRAME_W-1:0] nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPAT; i++) pat_q[i] <= '0;
      end else if (pat_we) begin
         for (int i = 0; i < NPAT; i++)
            if (pat_addr == PIDX_W'(i)) pat_q[i] <= pat_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          idx_q <= '0;
      else if (!test_mode)                 idx_q <= '0;
      else if (idx_q == PIDX_W'(NPAT - 1)) idx_q <= '0;
      else                                 idx_q <= idx_q + 1'b1;
   end

   always_comb begin
      nxt = '0;
      if (bc0) begin
         nxt[FRAME_W-1 -: KIND_W] = FK_ORBIT;
         nxt[NCH +: SIG_W]        = ORBIT_SIG[SIG_W-1:0];
         nxt[NCH-1:0]             = seq_err;
      end else if (test_mode) begin
         nxt[FRAME_W-1 -: KIND_W] = FK_PATTERN;
         nxt[PAT_W +: PIDX_W]     = idx_q;
         nxt[PAT_W-1:0]           = pat_q[idx_q];
      end else begin
         nxt[FRAME_W-1 -: KIND_W] = FK_SAMPLE;
         nxt[SLOTS_W]             = valid_in;
         nxt[SLOTS_W-1:0]         = slots;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame <= '0;
      else        frame <= nxt;
   end
endmodule

// File: rtl/dual_chan_framer.sv
`timescale 1ns/1ps
module dual_chan_framer
   import dfr_pkg::*;
#(
   parameter int          EXP_W     = 2,
   parameter int          MAN_W     = 5,
   parameter int          TAG_W     = 2,
   parameter int          NPAT      = 20,
   parameter int          PAT_W     = 8,
   parameter bit          HAS_FALL  = 1'b1,
   parameter logic [31:0] ORBIT_SIG = 32'h0001_5A3C,
   localparam int         NCH       = 2,
   localparam int         SMP_W     = EXP_W + MAN_W,
   localparam int         SLOT_W    = SMP_W + TAG_W,
   localparam int         PIDX_W    = $clog2(NPAT),
   localparam int         FRAME_W   = KIND_W + 1 + NCH * SLOT_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SMP_W-1:0]   ch0_smp_i,
   input  logic [TAG_W-1:0]   ch0_tag_i,
   input  logic [SMP_W-1:0]   ch1_smp_i,
   input  logic [TAG_W-1:0]   ch1_tag_i,
   input  logic [2*NCH-1:0]   align_cfg_i,
   input  logic               bc0_i,
   input  logic               test_mode_i,
   input  logic               err_clr_i,
   input  logic               pat_we_i,
   input  logic [PIDX_W-1:0]  pat_addr_i,
   input  logic [PAT_W-1:0]   pat_wdata_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [NCH-1:0]     seq_err_o,
   output logic               tag_mismatch_o,
   output logic               dig_rst_o
);
   localparam int SIG_W = FRAME_W - KIND_W - NCH;

   generate
      if (EXP_W < 1 || MAN_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("dual_chan_framer: sample and tag widths must be positive");
      end
      if (NPAT < 2 || PIDX_W + PAT_W > FRAME_W - KIND_W) begin : g_bad_pat
         $error("dual_chan_framer: pattern bank does not fit the frame");
      end
      if (SIG_W < 1) begin : g_bad_sig
         $error("dual_chan_framer: no room for the orbit signature");
      end
   endgenerate

   logic [NCH*SLOT_W-1:0] raw_slots;
   logic [NCH*SLOT_W-1:0] al_slots;
   logic [NCH*TAG_W-1:0]  al_tags;
   logic [NCH-1:0]        armed;
   logic                  mismatch;
   logic                  dig_rst_q;
   logic                  mism_q;

   assign raw_slots = {ch1_tag_i, ch1_smp_i, ch0_tag_i, ch0_smp_i};

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_align
         dfr_chan_align #(.W(SLOT_W), .HAS_FALL(HAS_FALL)) u_align (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_word  (raw_slots[c*SLOT_W +: SLOT_W]),
            .fall_cap (align_cfg_i[2*c+1]),
            .add_dly  (align_cfg_i[2*c]),
            .out_word (al_slots[c*SLOT_W +: SLOT_W])
         );
         assign al_tags[c*TAG_W +: TAG_W] = al_slots[c*SLOT_W + SMP_W +: TAG_W];
      end
   endgenerate

   dfr_tag_monitor #(.TAG_W(TAG_W), .NCH(NCH)) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .tags     (al_tags),
      .resync   (bc0_i),
      .clr      (err_clr_i),
      .seq_err  (seq_err_o),
      .armed    (armed),
      .mismatch (mismatch)
   );

   dfr_frame_mux #(
      .SLOTS_W   (NCH*SLOT_W),
      .NCH       (NCH),
      .NPAT      (NPAT),
      .PAT_W     (PAT_W),
      .PIDX_W    (PIDX_W),
      .FRAME_W   (FRAME_W),
      .ORBIT_SIG (ORBIT_SIG)
   ) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .slots     (al_slots),
      .valid_in  ((&armed) && !mismatch),
      .bc0       (bc0_i),
      .test_mode (test_mode_i),
      .seq_err   (seq_err_o),
      .pat_we    (pat_we_i),
      .pat_addr  (pat_addr_i),
      .pat_wdata (pat_wdata_i),
      .frame     (frame_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dig_rst_q <= 1'b0;
         mism_q    <= 1'b0;
      end else begin
         dig_rst_q <= bc0_i;
         mism_q    <= mismatch;
      end
   end

   assign dig_rst_o      = dig_rst_q;
   assign tag_mismatch_o = mism_q;
endmodule

// File: rtl/dfr_framer_chk.sv
`timescale 1ns/1ps
module dfr_framer_chk #(
   parameter int SMP_W   = 7,
   parameter int TAG_W   = 2,
   parameter int NPAT    = 20,
   parameter int PAT_W   = 8,
   parameter int PIDX_W  = 5,
   parameter int FRAME_W = 21
)(
   input logic               clk,
   input logic               rst_n,
   input logic               bc0_i,
   input logic               test_mode_i,
   input logic               err_clr_i,
   input logic [FRAME_W-1:0] frame_o,
   input logic [1:0]         seq_err_o,
   input logic               tag_mismatch_o,
   input logic               dig_rst_o
);
   localparam int SLOT_W = SMP_W + TAG_W;
   logic [1:0]       kind;
   logic             vbit;
   logic [TAG_W-1:0] tg0;
   logic [TAG_W-1:0] tg1;
   assign kind = frame_o[FRAME_W-1 -: 2];
   assign vbit = frame_o[2*SLOT_W];
   assign tg0  = frame_o[SMP_W +: TAG_W];
   assign tg1  = frame_o[SLOT_W + SMP_W +: TAG_W];

   p_orbit_after_bc0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bc0_i |=> (kind == 2'b01) && dig_rst_o);
   p_rst_only_on_bc0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bc0_i |=> !dig_rst_o);
   p_resume_after_orbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b01) && !bc0_i |=> kind != 2'b01);
   p_pattern_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode_i && !bc0_i |=> kind == 2'b10);
   p_pattern_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b10) |-> (int'(frame_o[PAT_W +: PIDX_W]) < NPAT));
   p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr_i |=> seq_err_o == 2'b00);
   p_sticky_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr_i |=> ((seq_err_o & $past(seq_err_o)) == $past(seq_err_o)));
   p_valid_tags_equal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b00) && vbit |-> (tg0 == tg1) && !tag_mismatch_o);
   p_mismatch_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b00) && tag_mismatch_o |-> (tg0 != tg1) && !vbit);
endmodule

bind dual_chan_framer dfr_framer_chk #(
   .SMP_W(SMP_W), .TAG_W(TAG_W), .NPAT(NPAT), .PAT_W(PAT_W),
   .PIDX_W(PIDX_W), .FRAME_W(FRAME_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bc0_i(bc0_i), .test_mode_i(test_mode_i),
   .err_clr_i(err_clr_i), .frame_o(frame_o), .seq_err_o(seq_err_o),
   .tag_mismatch_o(tag_mismatch_o), .dig_rst_o(dig_rst_o)
);

// File: tb/sim_dual_chan_framer.sv
`timescale 1ns/1ps
module sim_dual_chan_framer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  ch0_smp_i, ch1_smp_i;
   logic [1:0]  ch0_tag_i, ch1_tag_i;
   logic [3:0]  align_cfg_i;
   logic        bc0_i, test_mode_i, err_clr_i, pat_we_i;
   logic [4:0]  pat_addr_i;
   logic [7:0]  pat_wdata_i;
   logic [20:0] frame_o;
   logic [1:0]  seq_err_o;
   logic        tag_mismatch_o, dig_rst_o;

   always #2 clk = ~clk;

   dual_chan_framer u0 (.*);

   int total = 0, bad = 0;
   int k = 0, drv_dly = 1, skew1 = 0, tbase = 0, glitch_at = -1, bc0_at = -1;
   bit done = 0;
   logic [6:0] h0d [64], h1d [64];
   logic [1:0] h0t [64], h1t [64];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic drive();
      int a = k & 63;
      ch0_smp_i = 7'(k*5 + 3);
      ch0_tag_i = 2'(k - tbase);
      ch1_smp_i = 7'((k-skew1)*11 + 1);
      ch1_tag_i = 2'(k - skew1 - tbase);
      if (k == glitch_at) ch1_tag_i = ch1_tag_i ^ 2'b10;
      bc0_i = (k == bc0_at);
      h0d[a] = ch0_smp_i; h0t[a] = ch0_tag_i;
      h1d[a] = ch1_smp_i; h1t[a] = ch1_tag_i;
   endtask

   task automatic step();
      @(posedge clk);
      #(drv_dly);
      k++;
      drive();
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic clear_errs();
      err_clr_i = 1'b1; step(); err_clr_i = 1'b0; step();
   endtask

   // sample frame kind plus both slots against the stimulus l0 / l1 steps back
   task automatic chk_smp(string req, int l0, int l1);
      int a0 = (k - l0) & 63;
      int a1 = (k - l1) & 63;
      chk(req, {12'd0, frame_o[20:19], frame_o[17:0]},
          {12'd0, 2'b00, h1t[a1], h1d[a1], h0t[a0], h0d[a0]});
   endtask

   task automatic t_reset();
      chk("R1 frame", frame_o, 0);
      chk("R1 seq_err", seq_err_o, 0);
      chk("R1 mismatch", tag_mismatch_o, 0);
      chk("R1 dig_rst", dig_rst_o, 0);
   endtask

   task automatic t_basic();
      align_cfg_i = 4'b0000;
      steps(6); clear_errs();
      for (int i = 0; i < 6; i++) begin
         step();
         chk_smp("R2 sample frame", 2, 2);
         chk("R11 valid", frame_o[18], 1);
         chk("R5 no mismatch", tag_mismatch_o, 0);
      end
      chk("R6 no seq error across wrap", seq_err_o, 0);
   endtask

   task automatic t_skew();
      skew1 = 1; align_cfg_i = 4'b0001;
      steps(6); clear_errs();
      for (int i = 0; i < 4; i++) begin
         step();
         chk_smp("R3 ch0 delayed lines up", 3, 2);
         chk("R3 valid after alignment", frame_o[18], 1);
      end
      chk("R3 no seq error", seq_err_o, 0);
      skew1 = 0; align_cfg_i = 4'b0100;
      steps(4);
      chk_smp("R3 ch1 delay only", 2, 3);
      align_cfg_i = 4'b0000;
      steps(4);
   endtask

   task automatic t_fall();
      drv_dly = 3; align_cfg_i = 4'b0010;
      steps(4);
      chk_smp("R4 ch0 falling capture", 3, 2);
      step();
      chk_smp("R4 ch0 falling capture", 3, 2);
      align_cfg_i = 4'b1000;
      steps(4);
      chk_smp("R4 ch1 falling capture", 2, 3);
      drv_dly = 1; align_cfg_i = 4'b0000;
      steps(4);
      chk_smp("R2 back to rising", 2, 2);
   endtask

   task automatic t_mismatch();
      int g;
      steps(4); clear_errs();
      chk("R6 cleared", seq_err_o, 0);
      g = k + 1; glitch_at = g;
      step(); step(); step();
      chk("R5 mismatch flag", tag_mismatch_o, 1);
      chk("R5 valid low", frame_o[18], 0);
      chk_smp("R5 differing tags framed", 2, 2);
      step();
      chk("R5 mismatch drops", tag_mismatch_o, 0);
      steps(2);
      chk("R6 only ch1 error", seq_err_o, 2'b10);
      steps(3);
      chk("R6 sticky", seq_err_o, 2'b10);
      clear_errs();
      chk("R6 clear", seq_err_o, 0);
      glitch_at = -1;
   endtask

   task automatic t_orbit();
      steps(3); clear_errs();
      bc0_at = k + 1; tbase = k + 1;
      step();
      step();
      chk("R7 orbit kind", frame_o[20:19], 2'b01);
      chk("R7 orbit signature", frame_o[18:2], 17'h15A3C);
      chk("R7 orbit error bits", frame_o[1:0], 0);
      chk("R7 digitizer reset", dig_rst_o, 1);
      step();
      chk_smp("R7 samples resume", 2, 2);
      chk("R7 reset one cycle", dig_rst_o, 0);
      chk("R11 valid low while rearming", frame_o[18], 0);
      step();
      chk("R11 valid after rearm", frame_o[18], 1);
      steps(5);
      chk("R8 restart gives no error", seq_err_o, 0);
   endtask

   task automatic t_pattern();
      for (int i = 0; i < 20; i++) begin
         pat_we_i = 1'b1; pat_addr_i = 5'(i); pat_wdata_i = 8'(8'h40 + i*3);
         step();
      end
      pat_addr_i = 5'd20; pat_wdata_i = 8'hEE; step();
      pat_addr_i = 5'd31; step();
      pat_we_i = 1'b0;
      test_mode_i = 1'b1;
      for (int i = 0; i < 24; i++) begin
         step();
         chk("R9 pattern kind", frame_o[20:19], 2'b10);
         chk("R9 pattern index", frame_o[12:8], i % 20);
         chk("R10 pattern contents", frame_o[7:0], 8'(8'h40 + (i % 20)*3));
      end
      bc0_at = k + 1; tbase = k + 1;
      step(); step();
      chk("R9 orbit beats pattern", frame_o[20:19], 2'b01);
      step();
      chk("R9 pattern resumes", frame_o[20:19], 2'b10);
      test_mode_i = 1'b0;
      step(); step();
      chk("R9 samples after test mode", frame_o[20:19], 2'b00);
   endtask

   initial begin
      #(4*100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; align_cfg_i = '0; bc0_i = 0; test_mode_i = 0; err_clr_i = 0;
      pat_we_i = 0; pat_addr_i = '0; pat_wdata_i = '0;
      ch0_smp_i = '0; ch1_smp_i = '0; ch0_tag_i = '0; ch1_tag_i = '0;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_skew();
      t_fall();
      t_mismatch();
      t_orbit();
      t_pattern();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule